// File: doc/BRIEF.md
# PCI Interrupt Router with Legacy-Mapping Detection

This block merges the four interrupt pins (INTA to INTD) of every device slot on a small PCI bus into four level-sensitive, active-high system interrupt lines. A slot's pin reaches the output line chosen by a slot-dependent rotation. The amount of rotation depends on which of two board variants the block is serving.

Some guest software assumes an older, incorrect routing. In that routing, pin n of every slot goes to output n with no rotation. On the first board variant, the block watches configuration writes to the interrupt-line register of any function. A three-state tracker classifies the first write that tells the two kinds of software apart. The tracker then switches to the legacy routing or pins the correct routing for good. A reset-time mode input can preload the tracker, which skips detection.

The tracker is a single registered state, and the routing is purely combinational from the pins and that state. A detecting write therefore changes the routing from the cycle after the clock edge that samples it.

Top module: `pci_irq_router`

## Requirements
- R1: While `rst_n` is low, `map_state` loads from `reset_mode`, using the codes 0 = assume-ok, 1 = legacy (broken) and 2 = forced-ok. A `reset_mode` of 3 loads assume-ok. `map_state` never shows 3.
- R2: A classification happens only on a cycle with `cfg_wr` high, `cfg_addr[7:0]` equal to 0x3C, `variant_sel` low and `map_state` equal to assume-ok. On every other cycle the state is unchanged.
- R3: The slot number is `cfg_addr[15:11]`, and only its value modulo 4 (`cfg_addr[12:11]`) is used. The function bits `cfg_addr[10:8]` have no effect.
- R4: A classified write of value 27 leaves the state at assume-ok when slot mod 4 is 2, and moves it to legacy otherwise.
- R5: A classified write of any other value moves the state to legacy if the value equals (slot mod 4) + 27 or (slot mod 4) + 91, and to forced-ok if not.
- R6: Once the state is legacy or forced-ok, no write changes it until the next reset.
- R7: With `variant_sel` low and the state not legacy, pin p (0 = INTA) of the slot with bus number s drives output (s + p + 2) mod 4.
- R8: With `variant_sel` high, pin p of slot s drives output (s + p + 3) mod 4 in every state.
- R9: With `variant_sel` low and the state legacy, pin p of every slot drives output p.
- R10: Each output is the OR of all pins currently routed to it. It follows the pins in the same cycle with no register.
- R11: With `variant_sel` high no write ever changes the state, so the state stays at its reset value.
- R12: The state sampled at a clock edge with a classifying write takes effect on `map_state` and on the routing right after that edge, and not before it.
- R13: Physical slot index i of `slot_irq` (bits 4i+3..4i, INTA in the low bit) is the bus slot FIRST_SLOT + i (default 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 16 | Configuration address: register offset [7:0], function [10:8], slot [15:11] |
| cfg_wdata | input | 8 | Byte written to the addressed register |
| variant_sel | input | 1 | Board variant: 0 = first (detection, rotation 2), 1 = second (rotation 3) |
| reset_mode | input | 2 | Tracker value loaded during reset |
| slot_irq | input | 4*NUM_SLOTS | Interrupt pin levels, four per slot, INTA lowest |
| irq_out | output | 4 | System interrupt lines, active high |
| map_state | output | 2 | Current mapping state code |

## Verification
A classifying configuration write and live interrupt traffic can land on the same clock. The routing must then still use the old mapping up to the edge and switch to the new one right after it. The bench holds one slot pin high while it issues a write that forces the legacy mapping. It reads `irq_out` and `map_state` just before that edge, expecting the rotated output line and the assume-ok code. It reads them again just after the edge, expecting the unrotated line and the legacy code. Both expected lines are computed from the slot arithmetic.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef enum logic [1:0] {
    MAP_ASSUME = 2'd0,
    MAP_LEGACY = 2'd1,
    MAP_FORCED = 2'd2
  } map_state_e;

  localparam int unsigned PINS_PER_SLOT = 4;
  localparam int unsigned NUM_LINES     = 4;
  localparam logic [7:0]  LINE_REG_OFS  = 8'h3C;
  localparam logic [7:0]  PLAIN_BASE    = 8'd27;
  localparam logic [7:0]  SHIFTED_BASE  = 8'd91;

  // Map the reset-time mode code to a legal state; code 3 falls back to assume.
  function automatic map_state_e sanitize_mode(input logic [1:0] code);
    case (code)
      2'd1:    return MAP_LEGACY;
      2'd2:    return MAP_FORCED;
      default: return MAP_ASSUME;
    endcase
  endfunction

  // Classify one interrupt-line write by slot (mod 4) and value.
  function automatic map_state_e classify_write(input logic [1:0] slot_lo,
                                                input logic [7:0] value);
    logic [7:0] slot_ext;
    slot_ext = {6'd0, slot_lo};
    if (value == PLAIN_BASE) begin
      return (slot_lo == 2'd2) ? MAP_ASSUME : MAP_LEGACY;
    end
    if (value == PLAIN_BASE + slot_ext)   return MAP_LEGACY;
    if (value == SHIFTED_BASE + slot_ext) return MAP_LEGACY;
    return MAP_FORCED;
  endfunction

  // Rotated output line for pin 'pin' of a slot whose number mod 4 is 'slot_lo'.
  function automatic logic [1:0] rotate_line(input logic [1:0] slot_lo,
                                             input logic [1:0] pin,
                                             input logic       second_variant);
    logic [1:0] bias;
    bias = second_variant ? 2'd3 : 2'd2;
    return slot_lo + pin + bias;
  endfunction

endpackage

// File: rtl/pirq_cfg_decode.sv
module pirq_cfg_decode
  import pirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              line_hit,
  output logic [1:0]        slot_lo
);

  localparam int unsigned SLOT_LSB = 11;

  // Only the interrupt-line byte of any function is of interest.
  assign line_hit = cfg_wr && (cfg_addr[7:0] == LINE_REG_OFS);
  assign slot_lo  = cfg_addr[SLOT_LSB+1:SLOT_LSB];

endmodule

// File: rtl/pirq_detector.sv
module pirq_detector
  import pirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reset_mode,
  input  logic       variant_sel,
  input  logic       line_hit,
  input  logic [1:0] slot_lo,
  input  logic [7:0] wdata,
  output map_state_e state,
  output logic       det_fire,
  output map_state_e det_next
);

  // Evaluation event: only while undecided and on the first variant.
  assign det_fire = line_hit && !variant_sel && (state == MAP_ASSUME);
  assign det_next = classify_write(slot_lo, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= sanitize_mode(reset_mode);
    end else if (det_fire) begin
      state <= det_next;
    end
  end

endmodule

// File: rtl/pirq_route_matrix.sv
module pirq_route_matrix
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter int unsigned FIRST_SLOT = 11
) (
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] slot_irq,
  input  logic                               variant_sel,
  input  logic                               legacy,
  output logic [NUM_LINES-1:0]               irq_out
);

  localparam int unsigned NUM_PINS = NUM_SLOTS * PINS_PER_SLOT;

  logic [1:0] dest [NUM_PINS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [1:0] SLOT_LO = 2'((FIRST_SLOT + g) % 4);
    for (genvar p = 0; p < PINS_PER_SLOT; p++) begin : g_pin
      localparam logic [1:0] PIN = 2'(p);
      // Legacy mapping is only honoured on the first variant.
      assign dest[g*PINS_PER_SLOT+p] = (legacy && !variant_sel)
                                       ? PIN
                                       : rotate_line(SLOT_LO, PIN, variant_sel);
    end
  end

  always_comb begin
    irq_out = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      if (slot_irq[k]) irq_out[dest[k]] = 1'b1;
    end
  end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter int unsigned FIRST_SLOT = 11
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_wr,
  input  logic [15:0]                        cfg_addr,
  input  logic [7:0]                         cfg_wdata,
  input  logic                               variant_sel,
  input  logic [1:0]                         reset_mode,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] slot_irq,
  output logic [NUM_LINES-1:0]               irq_out,
  output logic [1:0]                         map_state
);

  logic       line_hit;
  logic [1:0] slot_lo;
  logic       det_fire;
  map_state_e det_next;
  map_state_e state;

  pirq_cfg_decode #(.ADDR_W(16)) u_decode (
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .line_hit (line_hit),
    .slot_lo  (slot_lo)
  );

  pirq_detector u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_mode  (reset_mode),
    .variant_sel (variant_sel),
    .line_hit    (line_hit),
    .slot_lo     (slot_lo),
    .wdata       (cfg_wdata),
    .state       (state),
    .det_fire    (det_fire),
    .det_next    (det_next)
  );

  pirq_route_matrix #(
    .NUM_SLOTS  (NUM_SLOTS),
    .FIRST_SLOT (FIRST_SLOT)
  ) u_route (
    .slot_irq    (slot_irq),
    .variant_sel (variant_sel),
    .legacy      (state == MAP_LEGACY),
    .irq_out     (irq_out)
  );

  assign map_state = state;

endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_wr,
  input logic [15:0]            cfg_addr,
  input logic [7:0]             cfg_wdata,
  input logic                   variant_sel,
  input logic [NUM_SLOTS*4-1:0] slot_irq,
  input logic [3:0]             irq_out,
  input logic [1:0]             map_state,
  input logic                   line_hit,
  input logic                   det_fire
);

  logic undecided_hit;
  assign undecided_hit = cfg_wr && (cfg_addr[7:0] == 8'h3C) && !variant_sel
                         && (map_state == 2'd0);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    map_state != 2'd3); // R1

  AST_QUIET_WITHOUT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !line_hit |=> $stable(map_state)); // R2

  AST_FIRE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    det_fire |-> line_hit); // R2

  AST_KEEP_SLOT2_27: assert property (@(posedge clk) disable iff (!rst_n)
    (undecided_hit && cfg_addr[12:11] == 2'd2 && cfg_wdata == 8'd27)
    |=> map_state == 2'd0); // R4

  AST_SHIFTED_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    (undecided_hit && cfg_wdata == 8'd91 + {6'd0, cfg_addr[12:11]})
    |=> map_state == 2'd1); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (map_state != 2'd0) |=> $stable(map_state)); // R6

  AST_LEGACY_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (map_state == 2'd1 && !variant_sel && slot_irq == {NUM_SLOTS{4'b0010}})
    |-> irq_out == 4'b0010); // R9

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_irq == '0) |-> irq_out == 4'b0000); // R10

  AST_SINGLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slot_irq) == 1) |-> $countones(irq_out) == 1); // R10

  AST_NO_DETECT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    variant_sel |=> $stable(map_state)); // R11

endmodule

bind pci_irq_router pirq_checker #(.NUM_SLOTS(NUM_SLOTS)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .variant_sel (variant_sel),
  .slot_irq    (slot_irq),
  .irq_out     (irq_out),
  .map_state   (map_state),
  .line_hit    (line_hit),
  .det_fire    (det_fire)
);

// File: tb/tb_pci_irq_router.sv
`timescale 1ns/1ps
module tb_pci_irq_router;

  localparam int NS = 4;
  localparam int FS = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [15:0]   cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          variant_sel = 1'b0;
  logic [1:0]    reset_mode = 2'd0;
  logic [NS*4-1:0] slot_irq = '0;
  logic [3:0]    irq_out;
  logic [1:0]    map_state;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_irq_router #(.NUM_SLOTS(NS), .FIRST_SLOT(FS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .variant_sel(variant_sel), .reset_mode(reset_mode),
    .slot_irq(slot_irq), .irq_out(irq_out), .map_state(map_state)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int mode, input bit var2);
    @(negedge clk);
    rst_n = 1'b0; reset_mode = 2'(mode); variant_sel = var2;
    cfg_wr = 1'b0; slot_irq = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input int slot, input int func, input int ofs, input int val);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_addr = {5'(slot), 3'(func), 8'(ofs)};
    cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
  endtask

  function automatic int exp_class(input int slot, input int val);
    int s = slot % 4;
    if (val == 27) return (s == 2) ? 0 : 1;
    if (val - 27 == s || val - 91 == s) return 1;
    return 2;
  endfunction

  function automatic int exp_lines(input int pat, input int st, input bit var2);
    int r = 0;
    for (int g = 0; g < NS; g++)
      for (int p = 0; p < 4; p++)
        if ((pat >> (g*4 + p)) & 1) begin
          int o;
          if (st == 1 && !var2) o = p;
          else o = (FS + g + p + (var2 ? 3 : 2)) % 4;
          r |= (1 << o);
        end
    return r;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset loads the mode, code 3 falls back to assume
    for (int m = 0; m < 4; m++) begin
      do_reset(m, 1'b0);
      check("R1 reset state", map_state, (m == 3) ? 0 : m);
      check("R1 idle lines", irq_out, 0);
    end

    // R3 R4 R5: exhaustive classification sweep over slots 0..7 and all bytes
    for (int sl = 0; sl < 8; sl++)
      for (int v = 0; v < 256; v++) begin
        do_reset(0, 1'b0);
        cfg_write(sl + 8 * (v % 4), v % 8, 8'h3C, v);
        check((v == 27) ? "R4 classify" : "R5 classify", map_state, exp_class(sl, v));
      end

    // R2: wrong offset and missing strobe leave the state alone
    do_reset(0, 1'b0);
    cfg_write(1, 0, 8'h3D, 8'h55);
    check("R2 other offset", map_state, 0);
    @(negedge clk);
    cfg_addr = 16'h083C; cfg_wdata = 8'h55; cfg_wr = 1'b0;
    @(negedge clk);
    check("R2 no strobe", map_state, 0);

    // R11: second variant never detects
    do_reset(0, 1'b1);
    cfg_write(1, 0, 8'h3C, 8'h55);
    check("R11 no detect", map_state, 0);
    do_reset(0, 1'b1);
    cfg_write(0, 0, 8'h3C, 27);
    check("R11 no detect legacy value", map_state, 0);

    // R6: sticky in both decided states
    do_reset(0, 1'b0);
    cfg_write(3, 0, 8'h3C, 94);
    check("R6 first legacy", map_state, 1);
    cfg_write(3, 0, 8'h3C, 8'h55);
    check("R6 stays legacy", map_state, 1);
    do_reset(2, 1'b0);
    cfg_write(1, 0, 8'h3C, 28);
    check("R6 stays forced", map_state, 2);
    do_reset(0, 1'b0);
    cfg_write(0, 0, 8'h3C, 8'h40);
    cfg_write(0, 0, 8'h3C, 27);
    check("R6 forced then legacy value", map_state, 2);
    // slot mod 4 == 2 with 27 keeps undecided, later write still classifies
    do_reset(0, 1'b0);
    cfg_write(2, 0, 8'h3C, 27);
    cfg_write(1, 0, 8'h3C, 28);
    check("R4 later write classifies", map_state, 1);

    // R7 R8 R9 R10 R13: routing sweep per variant and state
    for (int vv = 0; vv < 2; vv++)
      for (int m = 0; m < 3; m++) begin
        do_reset(m, vv[0]);
        for (int k = 0; k < NS*4; k++) begin
          @(negedge clk);
          slot_irq = 16'(1 << k);
          #1;
          check((m == 1 && vv == 0) ? "R9 single pin" : (vv ? "R8 single pin" : "R7 single pin"),
                irq_out, exp_lines(1 << k, m, vv[0]));
        end
        for (int k = 0; k < 600; k++) begin
          int pat = (k * 40503 + 7) & 16'hFFFF;
          @(negedge clk);
          slot_irq = 16'(pat);
          #1;
          check("R10 R13 pattern OR", irq_out, exp_lines(pat, m, vv[0]));
        end
      end

    // R12: write and live interrupt on the same edge
    do_reset(0, 1'b0);
    @(negedge clk);
    slot_irq = 16'h0001;
    cfg_wr = 1'b1; cfg_addr = {5'd1, 3'd0, 8'h3C}; cfg_wdata = 8'd28;
    #1;
    check("R12 before edge lines", irq_out, exp_lines(1, 0, 1'b0));
    check("R12 before edge state", map_state, 0);
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
    check("R12 after edge lines", irq_out, exp_lines(1, 1, 1'b0));
    check("R12 after edge state", map_state, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule